// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one 16-bit timer channel. It holds an initial count, a mode and a number base (binary or four-digit BCD). It counts down by one on each cycle in which the counting-clock enable is high and counting is allowed. It drives an output waveform whose shape depends on the mode, and it shows the live count at all times. A surrounding bus block decodes host writes, assembles the 16-bit value and then pulses `load_stb` with the value, the mode code and the base select. Latching and readback of the count are left to that bus block.

A load does not change the count at once. It arms a reload, and the next counting tick copies the initial count into the counter. That tick is elapsed count zero. Each later tick adds one to the elapsed count. An initial count of zero acts as the largest count, 65536 in binary or 10000 in BCD. The six modes split into two groups. In one-shot modes 0, 1, 4 and 5 the counter wraps through zero. In periodic modes 2 and 3 it reloads itself.

Top module: `dct_channel`

## Requirements
- R1: Synchronous active-high `rst` leaves `count_q` = 0 and `out_q` = 0. The channel stays idle and ignores `cnt_en` until the first `load_stb`.
- R2: `load_stb` does not change `count_q` in its own cycle. The first later cycle with a counting tick sets `count_q` to the loaded value. A tick is `cnt_en` high with counting allowed. `count_q` changes only on ticks.
- R3: In binary mode (`bcd_sel` = 0) each tick after the reload subtracts one, and 0x0000 wraps to 0xFFFF. A loaded 0 therefore lasts 65536 ticks.
- R4: In BCD mode (`bcd_sel` = 1) the four nibbles of `count_q` are decimal digits, units digit in bits 3:0. A tick subtracts one with a borrow between digits, 0x0000 wraps to 0x9999, and a loaded 0 lasts 10000 ticks. The loaded value must hold valid digits.
- R5: Mode 0: `out_q` goes low on load. It goes high on the tick where the elapsed count reaches the initial count N and stays high while the counter keeps wrapping.
- R6: Mode 1 has the same output as mode 0: low while the elapsed count is below N, high from then on.
- R7: Mode 2: the counter runs N, N-1, ... 1 and then reloads N. `out_q` is high for exactly the count that follows each self-reload, which is when the elapsed count is a nonzero multiple of N.
- R8: Mode 3: with the same N..1 cycle, `out_q` is high while (elapsed mod N) < (N+1)/2 and low for the rest of the period. N = 1 keeps it high.
- R9: Modes 4 and 5: `out_q` is high for one count only, on the tick where the elapsed count equals N. It does not pulse again after later wraps.
- R10: In modes 0 and 4 a low `gate` pauses counting and a rising edge does nothing else. In modes 1, 2, 3 and 5 the `gate` level is ignored. A rising edge there, once the channel is running, re-arms the reload so the next tick restarts from N, and `out_q` holds until that tick.
- R11: Mode codes 6 and 7 behave as modes 2 and 3. `mode_code` and `bcd_sel` are taken only with `load_stb`.
- R12: A cycle with `load_stb` or a gate retrigger is never a tick, even with `cnt_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_stb | input | 1 | Takes load_val, mode_code and bcd_sel and arms a reload |
| load_val | input | 16 | Initial count (0 means the maximum) |
| mode_code | input | 3 | Operating mode 0..7 |
| bcd_sel | input | 1 | 1 = four-digit BCD counting |
| gate | input | 1 | Gate level, pause or retrigger by mode |
| cnt_en | input | 1 | Counting-clock enable, one count per high cycle |
| out_q | output | 1 | Mode-dependent output waveform |
| count_q | output | 16 | Live counter value |

## Verification
Both outputs are registered. The result of a tick, load or retrigger taken at one rising edge shows up right after that same edge. The bench drives a cycle's inputs at the falling edge and computes the expected count and output from an elapsed-count model. It queues that expectation just after the following rising edge, and a monitor compares it with the ports at the next falling edge. So every cycle is compared exactly one edge after its stimulus. The model works from the elapsed count and modular arithmetic, not from a copy of the decrement-and-reload logic. This makes wrap, self-reload and the timing of the single strobe separate checks on the design's counter path.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int CW  = 16;
  localparam int ND  = CW / 4;
  localparam int EW  = CW + 1;

  typedef logic [CW-1:0] cnt_t;
  typedef logic [EW-1:0] eff_t;

  typedef enum logic [2:0] {
    MD_TERM   = 3'd0,
    MD_ONESHT = 3'd1,
    MD_RATE   = 3'd2,
    MD_SQUARE = 3'd3,
    MD_SWSTB  = 3'd4,
    MD_HWSTB  = 3'd5
  } mode_e;

  function automatic mode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

  function automatic logic gate_pauses(input mode_e m);
    return (m == MD_TERM) || (m == MD_SWSTB);
  endfunction

  function automatic logic gate_retrig(input mode_e m);
    return (m == MD_ONESHT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTB);
  endfunction

  function automatic int pow10(input int n);
    int acc;
    acc = 1;
    for (int i = 0; i < n; i++) acc = acc * 10;
    return acc;
  endfunction

  // one count down, binary wraps through all ones, BCD borrows digit by digit
  function automatic cnt_t dec_count(input cnt_t v, input logic bcd);
    cnt_t r;
    logic borrow;
    if (!bcd) return v - cnt_t'(1);
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < ND; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) begin
          r[4*i +: 4] = 4'd9;
        end else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // numeric weight of a counter value, zero standing for the full range
  function automatic eff_t eff_value(input cnt_t v, input logic bcd);
    int acc;
    if (v == '0) return bcd ? EW'(pow10(ND)) : (eff_t'(1) << CW);
    if (!bcd) return eff_t'(v);
    acc = 0;
    for (int i = ND - 1; i >= 0; i--) acc = acc * 10 + int'(v[4*i +: 4]);
    return EW'(acc);
  endfunction

endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_stb,
  input  cnt_t       load_val,
  input  logic [2:0] mode_code,
  input  logic       bcd_sel,
  input  logic       gate,
  input  logic       cnt_en,
  output cnt_t       init_r,
  output mode_e      mode_r,
  output logic       bcd_r,
  output logic       pend_r,
  output logic       run_r,
  output logic       retrig,
  output logic       tick,
  output logic       reload,
  output logic       step
);

  logic gate_d;
  logic gate_rise;
  logic gate_ok;

  assign gate_rise = gate && !gate_d;
  assign retrig    = run_r && gate_rise && gate_retrig(mode_r) && !load_stb;
  assign gate_ok   = gate_pauses(mode_r) ? gate : 1'b1;
  assign tick      = cnt_en && run_r && gate_ok && !load_stb && !retrig;
  assign reload    = tick && pend_r;
  assign step      = tick && !pend_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d <= 1'b0;
      init_r <= '0;
      mode_r <= MD_TERM;
      bcd_r  <= 1'b0;
      pend_r <= 1'b0;
      run_r  <= 1'b0;
    end else begin
      gate_d <= gate;
      if (load_stb) begin
        init_r <= load_val;
        mode_r <= norm_mode(mode_code);
        bcd_r  <= bcd_sel;
        pend_r <= 1'b1;
        run_r  <= 1'b1;
      end else if (retrig) begin
        pend_r <= 1'b1;
      end else if (reload) begin
        pend_r <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dct_count.sv
module dct_count
  import dct_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  reload,
  input  logic  step,
  input  cnt_t  init_r,
  input  mode_e mode_r,
  input  logic  bcd_r,
  output cnt_t  count_r,
  output cnt_t  nxt_val,
  output logic  term_evt
);

  logic at_one;

  assign at_one   = (count_r == cnt_t'(1));
  assign term_evt = step && at_one;

  always_comb begin
    if (is_periodic(mode_r) && at_one) nxt_val = init_r;
    else                               nxt_val = dec_count(count_r, bcd_r);
  end

  always_ff @(posedge clk) begin
    if (rst)         count_r <= '0;
    else if (reload) count_r <= init_r;
    else if (step)   count_r <= nxt_val;
  end

endmodule

// File: rtl/dct_outgen.sv
module dct_outgen
  import dct_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_stb,
  input  logic  reload,
  input  logic  step,
  input  logic  term_evt,
  input  mode_e mode_r,
  input  logic  bcd_r,
  input  cnt_t  init_r,
  input  cnt_t  nxt_val,
  output logic  out_r
);

  logic done_r;
  logic sq_high;

  assign sq_high = eff_value(nxt_val, bcd_r) > (eff_value(init_r, bcd_r) >> 1);

  always_ff @(posedge clk) begin
    if (rst || load_stb) begin
      out_r  <= 1'b0;
      done_r <= 1'b0;
    end else if (reload) begin
      out_r  <= (mode_r == MD_SQUARE);
      done_r <= 1'b0;
    end else if (step) begin
      case (mode_r)
        MD_TERM, MD_ONESHT: begin
          out_r  <= done_r || term_evt;
          done_r <= done_r || term_evt;
        end
        MD_RATE:   out_r <= term_evt;
        MD_SQUARE: out_r <= sq_high;
        MD_SWSTB, MD_HWSTB: begin
          out_r  <= term_evt && !done_r;
          done_r <= done_r || term_evt;
        end
        default:   out_r <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode_code,
  input  logic          bcd_sel,
  input  logic          gate,
  input  logic          cnt_en,
  output logic          out_q,
  output logic [CW-1:0] count_q
);

  cnt_t  init_r;
  mode_e mode_r;
  logic  bcd_r;
  logic  pend_r;
  logic  run_r;
  logic  retrig_w;
  logic  tick_w;
  logic  reload_w;
  logic  step_w;
  cnt_t  nxt_w;
  logic  term_w;

  dct_ctrl u_ctrl (
    .clk(clk), .rst(rst), .load_stb(load_stb), .load_val(load_val),
    .mode_code(mode_code), .bcd_sel(bcd_sel), .gate(gate), .cnt_en(cnt_en),
    .init_r(init_r), .mode_r(mode_r), .bcd_r(bcd_r), .pend_r(pend_r),
    .run_r(run_r), .retrig(retrig_w), .tick(tick_w), .reload(reload_w),
    .step(step_w)
  );

  dct_count u_count (
    .clk(clk), .rst(rst), .reload(reload_w), .step(step_w), .init_r(init_r),
    .mode_r(mode_r), .bcd_r(bcd_r), .count_r(count_q), .nxt_val(nxt_w),
    .term_evt(term_w)
  );

  dct_outgen u_out (
    .clk(clk), .rst(rst), .load_stb(load_stb), .reload(reload_w),
    .step(step_w), .term_evt(term_w), .mode_r(mode_r), .bcd_r(bcd_r),
    .init_r(init_r), .nxt_val(nxt_w), .out_r(out_q)
  );

endmodule

// File: rtl/dct_channel_chk.sv
module dct_channel_chk
  import dct_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  load_stb,
  input logic  gate,
  input logic  cnt_en,
  input logic  out_q,
  input cnt_t  count_q,
  input mode_e mode_r,
  input logic  bcd_r,
  input logic  pend_r,
  input logic  tick_w,
  input logic  step_w
);

  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int i = 0; i < ND; i++)
      if (count_q[4*i +: 4] > 4'd9) digits_ok = 1'b0;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_q == '0) && !out_q); // R1

  AST_LOAD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> $stable(count_q)); // R2

  AST_NO_ENABLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count_q)); // R2

  AST_GATE_PAUSE: assert property (@(posedge clk) disable iff (rst)
    ((mode_r == MD_TERM) || (mode_r == MD_SWSTB)) && !gate && !load_stb
      |=> $stable(count_q)); // R10

  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
    bcd_r && !pend_r |-> digits_ok); // R4

  AST_STROBE_ONE_COUNT: assert property (@(posedge clk) disable iff (rst)
    ((mode_r == MD_SWSTB) || (mode_r == MD_HWSTB)) && out_q && tick_w
      |=> !out_q); // R9

  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MD_TERM) && out_q && !load_stb && !pend_r |=> out_q); // R5

  AST_RATE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MD_RATE) && step_w && (count_q == cnt_t'(1)) |=> out_q); // R7

endmodule

bind dct_channel dct_channel_chk u_chk (
  .clk(clk), .rst(rst), .load_stb(load_stb), .gate(gate), .cnt_en(cnt_en),
  .out_q(out_q), .count_q(count_q), .mode_r(mode_r), .bcd_r(bcd_r),
  .pend_r(pend_r), .tick_w(tick_w), .step_w(step_w)
);

// File: tb/sim_dct_channel.sv
module sim_dct_channel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode_code = '0;
  logic        bcd_sel = 1'b0;
  logic        gate = 1'b0;
  logic        cnt_en = 1'b0;
  logic        out_q;
  logic [15:0] count_q;

  int checks = 0;
  int errors = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  // reference model state
  int          m_N, m_d, m_mode;
  bit          m_run, m_pend, m_bcd, m_gd, m_out;
  logic [15:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct_channel u0 (
    .clk(clk), .rst(rst), .load_stb(load_stb), .load_val(load_val),
    .mode_code(mode_code), .bcd_sel(bcd_sel), .gate(gate), .cnt_en(cnt_en),
    .out_q(out_q), .count_q(count_q)
  );

  function automatic int bcd_to_int(input logic [15:0] v);
    int r, w;
    r = 0; w = 1;
    for (int i = 0; i < 4; i++) begin
      r = r + int'(v[4*i +: 4]) * w;
      w = w * 10;
    end
    return r;
  endfunction

  function automatic logic [15:0] int_to_bcd(input int x);
    logic [15:0] r;
    int t;
    t = x;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic model_eval();
    int md, r, v;
    md = m_bcd ? 10000 : 65536;
    if (m_mode == 2 || m_mode == 3) begin
      r = m_d % m_N;
      v = m_N - r;
      m_out = (m_mode == 2) ? (r == 0 && m_d != 0) : (r < (m_N + 1) / 2);
    end else begin
      v = ((m_N - m_d) % md + md) % md;
      m_out = (m_mode <= 1) ? (m_d >= m_N) : (m_d == m_N);
    end
    if (v == md) v = 0;
    m_cnt = m_bcd ? int_to_bcd(v) : 16'(v);
  endtask

  task automatic drive(input bit ld, input logic [15:0] v, input logic [2:0] mc,
                       input bit b, input bit g, input bit en, input string tag);
    bit rise, rt, pause;
    @(negedge clk);
    load_stb = ld; load_val = v; mode_code = mc; bcd_sel = b; gate = g; cnt_en = en;
    rise = g && !m_gd;
    m_gd = g;
    if (ld) begin
      m_mode = (mc >= 6) ? int'(mc) - 4 : int'(mc);
      m_bcd  = b;
      m_N    = b ? bcd_to_int(v) : int'(v);
      if (m_N == 0) m_N = b ? 10000 : 65536;
      m_pend = 1; m_run = 1; m_out = 0;
    end else begin
      rt = m_run && rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5);
      pause = (m_mode == 0 || m_mode == 4) && !g;
      if (rt) m_pend = 1;
      else if (en && m_run && !pause) begin
        if (m_pend) begin m_d = 0; m_pend = 0; end
        else m_d = m_d + 1;
        model_eval();
      end
    end
    @(posedge clk);
    #1;
    exp_q.push_back({m_out, m_cnt});
    tag_q.push_back(tag);
  endtask

  task automatic ticks(input int n, input bit g, input string tag);
    for (int i = 0; i < n; i++) drive(0, 16'h0, 3'd0, 0, g, 1, tag);
  endtask

  task automatic load(input logic [15:0] v, input logic [2:0] mc, input bit b,
                      input string tag);
    drive(1, v, mc, b, 1, 0, tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (count_q !== e[15:0] || out_q !== e[16]) begin
        errors++;
        $display("FAIL %s count=%h/%h out=%b/%b (actual/expected)",
                 t, count_q, e[15:0], out_q, e[16]);
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_N = 1; m_d = 0; m_mode = 0; m_run = 0; m_pend = 0; m_bcd = 0;
    m_gd = 0; m_out = 0; m_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    checks++;
    if (count_q !== 16'h0 || out_q !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset count=%h/0000 out=%b/0", count_q, out_q);
    end
    ticks(3, 1, "R1 idle");

    // R2 R3 R5: mode 0 binary, with idle enable cycles between ticks
    load(16'd5, 3'd0, 0, "R2 load");
    drive(0, 0, 0, 0, 1, 0, "R2 no enable");
    ticks(4, 1, "R5 mode0");
    drive(0, 0, 0, 0, 1, 0, "R2 no enable");
    ticks(5, 1, "R3 R5 wrap");

    // R10: gate pause in mode 0
    load(16'd4, 3'd0, 0, "R10 load");
    ticks(2, 1, "R10 run");
    ticks(3, 0, "R10 paused");
    ticks(4, 1, "R10 resume");

    // R3: zero load counts as full range
    load(16'd0, 3'd0, 0, "R3 load0");
    ticks(3, 1, "R3 zero wrap");

    // R6 R10: mode 1 ignores gate level, retriggers on rising edge
    load(16'd6, 3'd1, 0, "R6 load");
    ticks(3, 1, "R6 mode1");
    ticks(1, 0, "R10 mode1 gate low");
    ticks(1, 1, "R12 R10 retrigger");
    ticks(8, 1, "R6 after retrigger");

    // R7 R8 R11: periodic modes
    load(16'd3, 3'd2, 0, "R7 load");
    ticks(10, 1, "R7 mode2");
    load(16'd4, 3'd6, 0, "R11 load code6");
    ticks(9, 1, "R11 code6");
    load(16'd5, 3'd3, 0, "R8 load");
    ticks(12, 1, "R8 mode3");
    load(16'd1, 3'd3, 0, "R8 load N1");
    ticks(3, 1, "R8 N1");
    load(16'd4, 3'd7, 0, "R11 load code7");
    ticks(5, 1, "R11 code7");
    ticks(1, 0, "R10 mode3 low");
    ticks(6, 1, "R10 mode3 retrigger");

    // R9 R10: strobe modes
    load(16'd3, 3'd4, 0, "R9 load");
    ticks(8, 1, "R9 mode4");
    load(16'd4, 3'd4, 0, "R10 load m4");
    ticks(2, 1, "R10 m4 run");
    ticks(2, 0, "R10 m4 paused");
    ticks(1, 1, "R10 m4 no retrigger");
    ticks(4, 1, "R9 m4 tail");
    load(16'd4, 3'd5, 0, "R9 load m5");
    ticks(3, 1, "R9 mode5");
    ticks(1, 0, "R10 m5 low");
    ticks(8, 1, "R10 m5 retrigger");

    // R4: BCD counting
    load(16'h0012, 3'd0, 1, "R4 load");
    ticks(15, 1, "R4 bcd mode0");
    load(16'h0010, 3'd2, 1, "R4 load m2");
    ticks(25, 1, "R4 R7 bcd mode2");
    load(16'h0000, 3'd4, 1, "R4 load0");
    ticks(10003, 1, "R4 R9 bcd full");

    // R12: load and enable in the same cycle
    drive(1, 16'd2, 3'd0, 0, 1, 1, "R12 load with enable");
    drive(1, 16'd3, 3'd0, 0, 1, 1, "R12 reload with enable");
    ticks(5, 1, "R12 after load");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule